// File: doc/BRIEF.md
# Panel Power and Display Sequencer

This block brings a display panel's driver chip up and down. It tracks two flags, power and display. When it takes a command (power up, display on, display off, standby), it walks a fixed program of register writes. Each write goes out through a request/done port to a separate serial engine, which owns the bit timing. Between groups of writes the block waits a number of milliseconds, counted from a prescaled tick.

An invert flag is folded into every display-control value the program writes. The gamma and geometry settings that belong to power-up come from a small ROM of index/value pairs, and the number of pairs is a parameter.

A display-on command that finds the power flag clear first runs the full power-up. When the power flag is set, it only restores the three registers that display-off altered. A command that would not change the current state finishes at once and issues nothing.

Top module: `pnl_power_seq`

## Requirements
- R1: After reset `powerOn`, `displayOn`, `busy` and `wrReq` are all 0.
- R2: Power-up runs only when the power flag is clear. It writes (index=value, hex): 10=0000, 00=0001, wait OSC_MS, 10=4444, 11=0001, 12=0003, 13=1119, 12=0013, wait PUMP_MS, 10=4440, 13=3119, wait SETTLE_MS. It then writes the ROM_DEPTH pairs (01=101B, 02=0700, 03=6020, 0C=0110 by default) and sets `powerOn`.
- R3: Each wait lasts at least its millisecond count times TICK_CYCLES clock cycles, and the next write follows within a few cycles after the wait ends.
- R4: Display-on with the power flag clear runs the R2 program and then the R5 program. With the power flag set it writes 12=0013, 0B=4400, 13=3119 and then runs the R5 program. `displayOn` never rises while `powerOn` is 0.
- R5: The display program writes 10=4740, waits PUMP_MS, writes 07=0041, waits GATE_MS, writes 07=0061 and 07=0063, waits GATE_MS, and writes 07=0073. It then issues an index-only request (`wrIndexOnly`=1) for register 22 and sets `displayOn`.
- R6: The register-07 values of R5 and R7 carry bit 2 set when the invert flag is 0 and clear when it is 1. `invSet` loads `invVal` into the invert flag only while `busy` is 0.
- R7: Display-off clears `displayOn` before its first write. It then writes 0B=4000, 07=0072, waits PUMP_MS, writes 07=0062, waits PUMP_MS, and writes 07=0000 (no invert merge), 10=0000, 12=0003, 13=1119.
- R8: Standby runs the R7 program first if `displayOn` is 1. It then clears `powerOn` and writes 10=0001, also when both flags are already clear.
- R9: `cmdOp` 0 = power-up, 1 = display-on, 2 = display-off, 3 = standby. Power-up with power set, display-on with display set, and display-off with display clear leave `busy` at 0 and issue no request.
- R10: A `cmdValid` or `invSet` arriving while `busy` is 1 is ignored, and no request is raised while `busy` is 0.
- R11: `wrReq` stays high, with `wrIdx`, `wrVal` and `wrIndexOnly` stable, until the cycle `wrDone` is seen. The next step starts only after that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdOp | input | 2 | Command code (R9) |
| invSet | input | 1 | Load the invert flag when idle |
| invVal | input | 1 | New invert flag value |
| wrDone | input | 1 | Serial engine finished the current request |
| busy | output | 1 | A program is running |
| powerOn | output | 1 | Power flag |
| displayOn | output | 1 | Display flag |
| wrReq | output | 1 | Register write request |
| wrIdx | output | 8 | Register index |
| wrVal | output | 16 | Register value (unused when index-only) |
| wrIndexOnly | output | 1 | Send the index message only |

## Verification
A request follows an accepted command, or the `wrDone` of the previous write, within a few cycles, except after a wait step. After a wait step the request is due no earlier than the wait's millisecond count times TICK_CYCLES. Each flag changes one cycle after its program step. The bench samples on the falling edge and timestamps every request against the previous done (or against the command). It accepts a request only inside the window the requirement allows. The bench's engine model holds `wrDone` off for two cycles so that it can see the request hold steady.

// File: rtl/pnl_seq_pkg.sv
package pnl_seq_pkg;

  typedef enum logic [1:0] {
    OP_PWRUP = 2'd0, OP_DISPON = 2'd1, OP_DISPOFF = 2'd2, OP_STBY = 2'd3
  } cmdOp_e;

  typedef enum logic [3:0] {
    K_WR, K_IDX, K_WAIT, K_ROM, K_SETPWR, K_SETDISP, K_CLRDISP,
    K_CLRPWR, K_PWRDONE, K_OFFDONE, K_END
  } kind_e;

  typedef enum logic [1:0] {W_OSC, W_PUMP, W_SETTLE, W_GATE} waitSel_e;

  typedef struct packed {
    kind_e    kind;
    logic [7:0]  idx;
    logic [15:0] val;
    logic     inv;
    waitSel_e wsel;
  } step_t;

  typedef struct packed {
    logic loadWait;
    logic loadWr;
    logic romNext;
    logic romClr;
    logic setPwr;
    logic clrPwr;
    logic setDisp;
    logic clrDisp;
    logic takeInv;
  } strobe_t;

  localparam int PC_W = 6;
  localparam logic [PC_W-1:0] PC_PWRUP   = 6'd0;
  localparam logic [PC_W-1:0] PC_RESTORE = 6'd15;
  localparam logic [PC_W-1:0] PC_DISPSEQ = 6'd18;
  localparam logic [PC_W-1:0] PC_DOFF    = 6'd29;
  localparam logic [PC_W-1:0] PC_STBY    = 6'd40;

  function automatic step_t mkWr(logic [7:0] i, logic [15:0] v, logic m);
    return '{kind: K_WR, idx: i, val: v, inv: m, wsel: W_OSC};
  endfunction

  function automatic step_t mkK(kind_e k, waitSel_e w);
    return '{kind: k, idx: 8'h00, val: 16'h0000, inv: 1'b0, wsel: w};
  endfunction

  function automatic step_t stepAt(logic [PC_W-1:0] pc);
    case (pc)
      6'd0:  return mkWr(8'h10, 16'h0000, 1'b0);
      6'd1:  return mkWr(8'h00, 16'h0001, 1'b0);
      6'd2:  return mkK(K_WAIT, W_OSC);
      6'd3:  return mkWr(8'h10, 16'h4444, 1'b0);
      6'd4:  return mkWr(8'h11, 16'h0001, 1'b0);
      6'd5:  return mkWr(8'h12, 16'h0003, 1'b0);
      6'd6:  return mkWr(8'h13, 16'h1119, 1'b0);
      6'd7:  return mkWr(8'h12, 16'h0013, 1'b0);
      6'd8:  return mkK(K_WAIT, W_PUMP);
      6'd9:  return mkWr(8'h10, 16'h4440, 1'b0);
      6'd10: return mkWr(8'h13, 16'h3119, 1'b0);
      6'd11: return mkK(K_WAIT, W_SETTLE);
      6'd12: return mkK(K_ROM, W_OSC);
      6'd13: return mkK(K_SETPWR, W_OSC);
      6'd14: return mkK(K_PWRDONE, W_OSC);
      6'd15: return mkWr(8'h12, 16'h0013, 1'b0);
      6'd16: return mkWr(8'h0B, 16'h4400, 1'b0);
      6'd17: return mkWr(8'h13, 16'h3119, 1'b0);
      6'd18: return mkWr(8'h10, 16'h4740, 1'b0);
      6'd19: return mkK(K_WAIT, W_PUMP);
      6'd20: return mkWr(8'h07, 16'h0041, 1'b1);
      6'd21: return mkK(K_WAIT, W_GATE);
      6'd22: return mkWr(8'h07, 16'h0061, 1'b1);
      6'd23: return mkWr(8'h07, 16'h0063, 1'b1);
      6'd24: return mkK(K_WAIT, W_GATE);
      6'd25: return mkWr(8'h07, 16'h0073, 1'b1);
      6'd26: return '{kind: K_IDX, idx: 8'h22, val: 16'h0000, inv: 1'b0, wsel: W_OSC};
      6'd27: return mkK(K_SETDISP, W_OSC);
      6'd28: return mkK(K_END, W_OSC);
      6'd29: return mkK(K_CLRDISP, W_OSC);
      6'd30: return mkWr(8'h0B, 16'h4000, 1'b0);
      6'd31: return mkWr(8'h07, 16'h0072, 1'b1);
      6'd32: return mkK(K_WAIT, W_PUMP);
      6'd33: return mkWr(8'h07, 16'h0062, 1'b1);
      6'd34: return mkK(K_WAIT, W_PUMP);
      6'd35: return mkWr(8'h07, 16'h0000, 1'b0);
      6'd36: return mkWr(8'h10, 16'h0000, 1'b0);
      6'd37: return mkWr(8'h12, 16'h0003, 1'b0);
      6'd38: return mkWr(8'h13, 16'h1119, 1'b0);
      6'd39: return mkK(K_OFFDONE, W_OSC);
      6'd40: return mkK(K_CLRPWR, W_OSC);
      6'd41: return mkWr(8'h10, 16'h0001, 1'b0);
      default: return mkK(K_END, W_OSC);
    endcase
  endfunction

  // Power-up settings table: {index, value}
  function automatic logic [23:0] romEntry(int i);
    case (i)
      0: return {8'h01, 16'h101B};
      1: return {8'h02, 16'h0700};
      2: return {8'h03, 16'h6020};
      3: return {8'h0C, 16'h0110};
      4: return {8'h08, 16'h0202};
      5: return {8'h09, 16'h0000};
      6: return {8'h40, 16'h0000};
      7: return {8'h41, 16'h0000};
      default: return 24'h0;
    endcase
  endfunction

endpackage

// File: rtl/pnl_seq_dp.sv
module pnl_seq_dp
  import pnl_seq_pkg::*;
#(
  parameter int TICK_CYCLES = 50000,
  parameter int OSC_MS      = 10,
  parameter int PUMP_MS     = 40,
  parameter int SETTLE_MS   = 167,
  parameter int GATE_MS     = 33,
  parameter int ROM_DEPTH   = 4
)(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  step_t       step,
  input  logic        invSet,
  input  logic        invVal,
  output logic        waitDone,
  output logic        romLast,
  output logic        powerFlag,
  output logic        dispFlag,
  output logic        invFlag,
  output logic [7:0]  wrIdx,
  output logic [15:0] wrVal,
  output logic        wrIndexOnly
);
  localparam int MAX_A  = (OSC_MS > PUMP_MS) ? OSC_MS : PUMP_MS;
  localparam int MAX_B  = (SETTLE_MS > GATE_MS) ? SETTLE_MS : GATE_MS;
  localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MS_W   = $clog2(MAX_MS + 1);
  localparam int PRE_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int ROM_PTR_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  logic [23:0] romMem [ROM_DEPTH];
  for (genvar g = 0; g < ROM_DEPTH; g++) begin : gRom
    assign romMem[g] = romEntry(g);
  end

  logic [PRE_W-1:0]     pre;
  logic [MS_W-1:0]      msLeft;
  logic [ROM_PTR_W-1:0] romPtr;
  logic [MS_W-1:0]      msLoad;

  always_comb begin
    unique case (step.wsel)
      W_OSC:    msLoad = MS_W'(OSC_MS);
      W_PUMP:   msLoad = MS_W'(PUMP_MS);
      W_SETTLE: msLoad = MS_W'(SETTLE_MS);
      default:  msLoad = MS_W'(GATE_MS);
    endcase
  end

  assign waitDone = (msLeft == '0);
  assign romLast  = (romPtr == ROM_PTR_W'(ROM_DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre <= '0; msLeft <= '0;
    end else if (stb.loadWait) begin
      msLeft <= msLoad;
      pre    <= PRE_W'(TICK_CYCLES - 1);
    end else if (msLeft != '0) begin
      if (pre == '0) begin
        pre    <= PRE_W'(TICK_CYCLES - 1);
        msLeft <= msLeft - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romPtr <= '0; powerFlag <= 1'b0; dispFlag <= 1'b0; invFlag <= 1'b0;
      wrIdx <= '0; wrVal <= '0; wrIndexOnly <= 1'b0;
    end else begin
      if (stb.romClr)      romPtr <= '0;
      else if (stb.romNext) romPtr <= romPtr + 1'b1;
      if (stb.setPwr)  powerFlag <= 1'b1;
      if (stb.clrPwr)  powerFlag <= 1'b0;
      if (stb.setDisp) dispFlag  <= 1'b1;
      if (stb.clrDisp) dispFlag  <= 1'b0;
      if (stb.takeInv && invSet) invFlag <= invVal;
      if (stb.loadWr) begin
        if (step.kind == K_ROM) begin
          {wrIdx, wrVal} <= romMem[romPtr];
          wrIndexOnly    <= 1'b0;
        end else begin
          wrIdx       <= step.idx;
          wrVal       <= step.val | ((step.inv && !invFlag) ? 16'h0004 : 16'h0000);
          wrIndexOnly <= (step.kind == K_IDX);
        end
      end
    end
  end

  assert_disp_needs_pwr_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispFlag) |-> powerFlag);
  assert_pwr_drop_after_disp_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerFlag) |-> !dispFlag);
  assert_timer_counts_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadWait && msLeft != '0) |=> msLeft <= $past(msLeft));
endmodule

// File: rtl/pnl_seq_ctrl.sv
module pnl_seq_ctrl
  import pnl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       powerFlag,
  input  logic       dispFlag,
  input  logic       waitDone,
  input  logic       romLast,
  input  logic       wrDone,
  output step_t      step,
  output strobe_t    stb,
  output logic       wrReq,
  output logic       busy
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WR, S_WT} state_e;
  state_e          state;
  logic [PC_W-1:0] pc;
  cmdOp_e          op;

  assign step  = stepAt(pc);
  assign wrReq = (state == S_WR);
  assign busy  = (state != S_IDLE);

  always_comb begin
    stb = '0;
    unique case (state)
      S_IDLE: stb.takeInv = 1'b1;
      S_RUN: begin
        case (step.kind)
          K_WR, K_IDX, K_ROM: stb.loadWr = 1'b1;
          K_WAIT:    stb.loadWait = 1'b1;
          K_SETPWR:  stb.setPwr   = 1'b1;
          K_SETDISP: stb.setDisp  = 1'b1;
          K_CLRDISP: stb.clrDisp  = 1'b1;
          K_CLRPWR:  stb.clrPwr   = 1'b1;
          default: ;
        endcase
      end
      S_WR: if (wrDone && step.kind == K_ROM) begin
        if (romLast) stb.romClr = 1'b1;
        else         stb.romNext = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; pc <= '0; op <= OP_PWRUP;
    end else begin
      unique case (state)
        S_IDLE: if (cmdValid) begin
          op <= cmdOp_e'(cmdOp);
          unique case (cmdOp_e'(cmdOp))
            OP_PWRUP:   if (!powerFlag) begin pc <= PC_PWRUP; state <= S_RUN; end
            OP_DISPON:  if (!dispFlag) begin
                          pc <= powerFlag ? PC_RESTORE : PC_PWRUP; state <= S_RUN;
                        end
            OP_DISPOFF: if (dispFlag) begin pc <= PC_DOFF; state <= S_RUN; end
            default:    begin pc <= dispFlag ? PC_DOFF : PC_STBY; state <= S_RUN; end
          endcase
        end
        S_RUN: begin
          case (step.kind)
            K_WR, K_IDX, K_ROM: state <= S_WR;
            K_WAIT:    state <= S_WT;
            K_PWRDONE: if (op == OP_DISPON) pc <= PC_DISPSEQ; else state <= S_IDLE;
            K_OFFDONE: if (op == OP_STBY) pc <= PC_STBY; else state <= S_IDLE;
            K_END:     state <= S_IDLE;
            default:   pc <= pc + 1'b1;
          endcase
        end
        S_WR: if (wrDone) begin
          if (!(step.kind == K_ROM && !romLast)) pc <= pc + 1'b1;
          state <= S_RUN;
        end
        default: if (waitDone) begin pc <= pc + 1'b1; state <= S_RUN; end
      endcase
    end
  end

  assert_hold_until_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrDone) |=> wrReq);
  assert_cmd_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> $stable(op));
endmodule

// File: rtl/pnl_power_seq.sv
module pnl_power_seq
  import pnl_seq_pkg::*;
#(
  parameter int TICK_CYCLES = 50000,
  parameter int OSC_MS      = 10,
  parameter int PUMP_MS     = 40,
  parameter int SETTLE_MS   = 167,
  parameter int GATE_MS     = 33,
  parameter int ROM_DEPTH   = 4
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic        invSet,
  input  logic        invVal,
  input  logic        wrDone,
  output logic        busy,
  output logic        powerOn,
  output logic        displayOn,
  output logic        wrReq,
  output logic [7:0]  wrIdx,
  output logic [15:0] wrVal,
  output logic        wrIndexOnly
);
  step_t   step;
  strobe_t stb;
  logic    waitDone, romLast, invFlag;

  pnl_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .powerFlag(powerOn), .dispFlag(displayOn), .waitDone(waitDone),
    .romLast(romLast), .wrDone(wrDone), .step(step), .stb(stb),
    .wrReq(wrReq), .busy(busy)
  );

  pnl_seq_dp #(
    .TICK_CYCLES(TICK_CYCLES), .OSC_MS(OSC_MS), .PUMP_MS(PUMP_MS),
    .SETTLE_MS(SETTLE_MS), .GATE_MS(GATE_MS), .ROM_DEPTH(ROM_DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .step(step), .invSet(invSet),
    .invVal(invVal), .waitDone(waitDone), .romLast(romLast),
    .powerFlag(powerOn), .dispFlag(displayOn), .invFlag(invFlag),
    .wrIdx(wrIdx), .wrVal(wrVal), .wrIndexOnly(wrIndexOnly)
  );

  assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrDone) |=> ($stable(wrIdx) && $stable(wrVal) && $stable(wrIndexOnly)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wrReq);
  assert_invert_merge_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrIdx == 8'h07 && wrVal != 16'h0000) |-> (wrVal[2] == !invFlag));
endmodule

// File: tb/pnl_power_seq_tb.sv
`timescale 1ns/1ps
module pnl_power_seq_tb_top;
  localparam int TICK = 4;
  localparam int OSC = 10, PUMP = 40, SETTLE = 167, GATE = 33;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, invSet = 1'b0, invVal = 1'b0, wrDone = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic busy, powerOn, displayOn, wrReq, wrIndexOnly;
  logic [7:0] wrIdx;
  logic [15:0] wrVal;

  always #2.5 clk = ~clk;

  pnl_power_seq #(.TICK_CYCLES(TICK)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .invSet(invSet), .invVal(invVal), .wrDone(wrDone), .busy(busy),
    .powerOn(powerOn), .displayOn(displayOn), .wrReq(wrReq), .wrIdx(wrIdx),
    .wrVal(wrVal), .wrIndexOnly(wrIndexOnly)
  );

  typedef struct {
    logic [7:0]  idx;
    logic [15:0] val;
    logic        io;
    int          wc;
  } item_t;
  item_t expQ[$];

  int total = 0, bad = 0, cyc = 0, doneCyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pw(logic [7:0] i, logic [15:0] v, int waitMs);
    item_t it;
    it.idx = i; it.val = v; it.io = 1'b0; it.wc = waitMs * TICK;
    expQ.push_back(it);
  endtask

  function automatic logic [15:0] mg(logic [15:0] v, bit inv);
    return inv ? v : (v | 16'h0004);
  endfunction

  task automatic expPowerUp();
    pw(8'h10, 16'h0000, 0); pw(8'h00, 16'h0001, 0);
    pw(8'h10, 16'h4444, OSC); pw(8'h11, 16'h0001, 0); pw(8'h12, 16'h0003, 0);
    pw(8'h13, 16'h1119, 0); pw(8'h12, 16'h0013, 0);
    pw(8'h10, 16'h4440, PUMP); pw(8'h13, 16'h3119, 0);
    pw(8'h01, 16'h101B, SETTLE); pw(8'h02, 16'h0700, 0);
    pw(8'h03, 16'h6020, 0); pw(8'h0C, 16'h0110, 0);
  endtask

  task automatic expRestore();
    pw(8'h12, 16'h0013, 0); pw(8'h0B, 16'h4400, 0); pw(8'h13, 16'h3119, 0);
  endtask

  task automatic expDispSeq(bit inv);
    item_t it;
    pw(8'h10, 16'h4740, 0);
    pw(8'h07, mg(16'h0041, inv), PUMP);
    pw(8'h07, mg(16'h0061, inv), GATE);
    pw(8'h07, mg(16'h0063, inv), 0);
    pw(8'h07, mg(16'h0073, inv), GATE);
    it.idx = 8'h22; it.val = 16'h0000; it.io = 1'b1; it.wc = 0;
    expQ.push_back(it);
  endtask

  task automatic expDoff(bit inv);
    pw(8'h0B, 16'h4000, 0); pw(8'h07, mg(16'h0072, inv), 0);
    pw(8'h07, mg(16'h0062, inv), PUMP); pw(8'h07, 16'h0000, PUMP);
    pw(8'h10, 16'h0000, 0); pw(8'h12, 16'h0003, 0); pw(8'h13, 16'h1119, 0);
  endtask

  // Monitor: models the serial engine and pops the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (wrReq && rstN) begin
        int gap;
        logic [7:0] i0;
        logic [15:0] v0;
        gap = cyc - doneCyc;
        i0 = wrIdx; v0 = wrVal;
        if (expQ.size() == 0) begin
          chk(1'b0, "R10 unexpected request", {wrIdx, wrVal}, 0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          chk(wrIdx == e.idx && wrVal == e.val && wrIndexOnly == e.io,
              "R2/R5/R7 write content", {wrIndexOnly, wrIdx, wrVal}, {e.io, e.idx, e.val});
          chk(gap >= e.wc && gap <= e.wc + 10, "R3 request timing", gap, e.wc);
        end
        repeat (2) @(negedge clk);
        chk(wrReq && wrIdx == i0 && wrVal == v0, "R11 request held",
            {wrReq, wrIdx, wrVal}, {1'b1, i0, v0});
        wrDone = 1'b1;
        doneCyc = cyc;
        @(negedge clk);
        wrDone = 1'b0;
      end
    end
  end

  task automatic startCmd(logic [1:0] op);
    @(negedge clk);
    doneCyc = cyc;
    cmdValid = 1'b1; cmdOp = op;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle(string tag);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  task automatic redundant(logic [1:0] op, string tag);
    startCmd(op);
    chk(!busy, tag, busy, 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", bad);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!powerOn && !displayOn && !busy && !wrReq, "R1 reset state",
        {powerOn, displayOn, busy, wrReq}, 0);

    // R9 display-off while display off
    redundant(2'd2, "R9 off while off");

    // R2 power-up from off
    expPowerUp();
    startCmd(2'd0);
    waitIdle("R2 power-up complete");
    chk(powerOn && !displayOn, "R2 flags after power-up", {powerOn, displayOn}, 2'b10);

    // R9 power-up again
    redundant(2'd0, "R9 power-up while on");

    // R4 restore path, R10 ignored inputs while busy, R6 default merge
    expRestore(); expDispSeq(1'b0);
    startCmd(2'd1);
    repeat (5) @(negedge clk);
    invSet = 1'b1; invVal = 1'b1; cmdValid = 1'b1; cmdOp = 2'd3;
    @(negedge clk);
    invSet = 1'b0; cmdValid = 1'b0;
    waitIdle("R4 restore and R5 display program");
    chk(powerOn && displayOn, "R5 display flag set", {powerOn, displayOn}, 2'b11);

    // R9 display-on again
    redundant(2'd1, "R9 display-on while on");

    // R6 invert taken while idle, R7 display-off
    @(negedge clk); invSet = 1'b1; invVal = 1'b1;
    @(negedge clk); invSet = 1'b0;
    expDoff(1'b1);
    startCmd(2'd2);
    while (!wrReq) @(negedge clk);
    chk(!displayOn, "R7 display flag cleared before first write", displayOn, 0);
    waitIdle("R7 display-off program");
    chk(powerOn && !displayOn, "R7 flags after off", {powerOn, displayOn}, 2'b10);

    // R8 standby with display off
    pw(8'h10, 16'h0001, 0);
    startCmd(2'd3);
    waitIdle("R8 standby from power-on");
    chk(!powerOn && !displayOn, "R8 power flag cleared", {powerOn, displayOn}, 0);

    // R4 display-on from power off, inverted R6
    expPowerUp(); expDispSeq(1'b1);
    startCmd(2'd1);
    waitIdle("R4 full power-up then display");
    chk(powerOn && displayOn, "R4 flags after full display-on", {powerOn, displayOn}, 2'b11);

    // R8 standby with display on
    @(negedge clk); invSet = 1'b1; invVal = 1'b0;
    @(negedge clk); invSet = 1'b0;
    expDoff(1'b0); pw(8'h10, 16'h0001, 0);
    startCmd(2'd3);
    waitIdle("R8 standby with display on");
    chk(!powerOn && !displayOn, "R8 all flags clear", {powerOn, displayOn}, 0);

    // R8 standby again from all-off
    pw(8'h10, 16'h0001, 0);
    startCmd(2'd3);
    waitIdle("R8 standby while off");
    chk(!powerOn, "R8 power stays clear", powerOn, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule